// File: doc/BRIEF.md
# Floating-Point Status Word Controller

This block keeps the floating-point status word that sits beside an FPU datapath. On each clock it accepts at most one of three updates: the raw exception flags of a finished operation, the outcome of a floating-point compare directed at one of four condition-code sets, or a software store of a new status word. It folds exceptions into the current and accrued exception fields, raises a one-cycle trap request when an exception is enabled, writes compare outcomes into the chosen condition-code field, and decodes the rounding field into a one-hot mode vector for the datapath.

The status word is 64 bits wide. Fields whose positions other logic relies on are the current-exception field at bits [4:0] (bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact), the accrued field five bits above it at [9:5], the trap-enable field 23 bits above it at [27:23], the trap-type field at [16:14], the rounding field at [31:30], and the condition-code sets at [11:10], [33:32], [35:34] and [37:36] (offsets 0, 22, 24 and 26 from the base set). A small controller has two states: `ST_IDLE` (no trap pending) and `ST_TRAP` (the cycle in which the trap request is driven). Transitions: `ST_IDLE -> ST_TRAP` and `ST_TRAP -> ST_TRAP` when an enabled exception is accepted; `ST_TRAP -> ST_IDLE` and `ST_IDLE -> ST_IDLE` otherwise.

Top module: `fpsr_ctl`

## Requirements
- R1: An active-low reset clears the whole status word to zero, leaves `trap_req` low and selects round-to-nearest (`rnd_onehot` = 4'b0001).
- R2: Each raw flag of an accepted operation is ORed into its own current-exception bit (bit 4 invalid, 3 overflow, 2 underflow, 1 divide-by-zero, 0 inexact); bits already set stay set.
- R3: When no enabled exception is present after that merge, the whole current-exception field is ORed into the accrued field at bits [9:5].
- R4: When the merged current-exception field ANDed with the enable field [27:23] is nonzero, the trap-type field [16:14] becomes 3'b001, the accrued field is left unchanged, and `trap_req` is high for exactly the following cycle.
- R5: An accepted operation whose flags are all zero leaves the status word unchanged and raises no trap.
- R6: A compare writes a 2-bit code (equal 00, less 01, greater 10, unordered 11, matching `cmp_rel`) into the set chosen by `cmp_sel`: set 0 at [11:10], set 1 at [33:32], set 2 at [35:34], set 3 at [37:36]; other sets are unchanged.
- R7: A signalling compare (`cmp_signal`=1) reports invalid when any operand is a NaN; a quiet compare reports invalid only when an operand is a signalling NaN; the invalid is then handled as in R2 to R4.
- R8: `rnd_onehot` decodes the rounding field [31:30]: 00 sets bit 0 (nearest-even), 01 bit 1 (toward zero), 10 bit 2 (toward +infinity), 11 bit 3 (toward -infinity), and follows a store on the next cycle.
- R9: A store replaces only bits [4:0], [9:5], [11:10], [27:23], [31:30] and [37:32] with `wr_data`; it clears the trap-type field; every other bit keeps its value.
- R10: A store takes priority over a compare and an operation in the same cycle, and a compare over an operation; the lower-priority inputs of that cycle are dropped.
- R11: Once set, the trap-type field holds its value until the next store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation flags are valid this cycle |
| op_flags | input | 5 | Raw exception flags of the finished operation |
| cmp_valid | input | 1 | Compare result is valid this cycle |
| cmp_rel | input | 2 | Compare outcome code |
| cmp_sel | input | 2 | Condition-code set to write |
| cmp_signal | input | 1 | 1 for signalling compare, 0 for quiet |
| cmp_any_nan | input | 1 | An operand is a NaN |
| cmp_any_snan | input | 1 | An operand is a signalling NaN |
| wr_valid | input | 1 | Software store of the status word |
| wr_data | input | 64 | Value stored under the writable mask |
| status | output | 64 | Current status word |
| trap_req | output | 1 | One-cycle trap request |
| rnd_onehot | output | 4 | Decoded rounding mode for the datapath |

## Verification
The bench goes after the split between trapping and accruing: a design that tested the raw flags instead of the merged current field would miss a trap caused by an earlier, still-set enabled bit, and one that accrued on a trap would show extra accrued bits. It drives every relation into every condition-code set, where a wrong shift would corrupt a neighbouring set or the enable field, and it distinguishes quiet from signalling compares on quiet and signalling NaNs, which a design that ignored `cmp_signal` would get wrong. Stores of all ones expose a mask that lets the trap-type or reserved bits through, and simultaneous store, compare and operation inputs expose a wrong priority as a merged or lost update.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int WORD_W   = 64;
    localparam int EXC_W    = 5;
    localparam int CC_SETS  = 4;
    localparam int CC_W     = 2;
    localparam int SEL_W    = $clog2(CC_SETS);
    localparam int RND_W    = 2;
    localparam int RND_MODES = 1 << RND_W;
    localparam int TT_W     = 3;

    // field positions that neighbouring logic decodes
    localparam int CEXC_LSB  = 0;
    localparam int AEXC_SHIFT = 5;
    localparam int AEXC_LSB  = CEXC_LSB + AEXC_SHIFT;
    localparam int CC0_LSB   = 10;
    localparam int TT_LSB    = 14;
    localparam int TEM_SHIFT = 23;
    localparam int TEM_LSB   = CEXC_LSB + TEM_SHIFT;
    localparam int RND_LSB   = 30;
    localparam int CC_EXTRA_BASE = 20;

    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

    // exception bit order inside a flag vector
    localparam int EXC_NX = 0;
    localparam int EXC_DZ = 1;
    localparam int EXC_UF = 2;
    localparam int EXC_OF = 3;
    localparam int EXC_NV = 4;

    typedef enum logic [1:0] {
        REL_EQ = 2'b00,
        REL_LT = 2'b01,
        REL_GT = 2'b10,
        REL_UN = 2'b11
    } rel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TRAP = 1'b1
    } st_e;

    // low bit of condition-code set i
    function automatic int cc_lsb(input int i);
        return (i == 0) ? CC0_LSB : CC0_LSB + CC_EXTRA_BASE + 2 * i;
    endfunction

    function automatic logic [WORD_W-1:0] field_mask(input int lsb, input int w);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int b = 0; b < w; b++) m[lsb + b] = 1'b1;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] store_mask();
        logic [WORD_W-1:0] m;
        m = field_mask(CEXC_LSB, EXC_W) | field_mask(AEXC_LSB, EXC_W)
          | field_mask(TEM_LSB, EXC_W)  | field_mask(RND_LSB, RND_W);
        for (int i = 0; i < CC_SETS; i++) m = m | field_mask(cc_lsb(i), CC_W);
        return m;
    endfunction

endpackage

// File: rtl/fpsr_cc_unit.sv
module fpsr_cc_unit
    import fpsr_pkg::*;
(
    input  logic               cmp_valid,
    input  logic [CC_W-1:0]    cmp_rel,
    input  logic [SEL_W-1:0]   cmp_sel,
    input  logic               cmp_signal,
    input  logic               cmp_any_nan,
    input  logic               cmp_any_snan,
    output logic [CC_SETS-1:0] cc_we,
    output logic [CC_W-1:0]    cc_val,
    output logic               cmp_invalid
);

    for (genvar g = 0; g < CC_SETS; g++) begin : g_sel
        assign cc_we[g] = cmp_valid && (cmp_sel == SEL_W'(g));
    end

    assign cc_val = cmp_rel;

    // signalling form: any NaN is invalid; quiet form: only signalling NaNs
    always_comb begin
        if (!cmp_valid)
            cmp_invalid = 1'b0;
        else if (cmp_signal)
            cmp_invalid = cmp_any_nan || cmp_any_snan;
        else
            cmp_invalid = cmp_any_snan;
    end

endmodule

// File: rtl/fpsr_exc_unit.sv
module fpsr_exc_unit
    import fpsr_pkg::*;
(
    input  logic [EXC_W-1:0] flags_in,
    input  logic [EXC_W-1:0] cexc_q,
    input  logic [EXC_W-1:0] aexc_q,
    input  logic [EXC_W-1:0] tem_q,
    output logic             any_flag,
    output logic             trap_hit,
    output logic [EXC_W-1:0] cexc_d,
    output logic [EXC_W-1:0] aexc_d
);

    logic [EXC_W-1:0] merged;

    always_comb begin
        any_flag = |flags_in;
        merged   = cexc_q | flags_in;
        trap_hit = any_flag && (|(merged & tem_q));
        cexc_d   = merged;
        aexc_d   = trap_hit ? aexc_q : (aexc_q | merged);
    end

endmodule

// File: rtl/fpsr_rnd_decode.sv
module fpsr_rnd_decode
    import fpsr_pkg::*;
(
    input  logic [RND_W-1:0]     rnd_field,
    output logic [RND_MODES-1:0] rnd_onehot
);

    for (genvar g = 0; g < RND_MODES; g++) begin : g_mode
        assign rnd_onehot[g] = (rnd_field == RND_W'(g));
    end

endmodule

// File: rtl/fpsr_ctl.sv
module fpsr_ctl
    import fpsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [EXC_W-1:0]     op_flags,
    input  logic                 cmp_valid,
    input  logic [CC_W-1:0]      cmp_rel,
    input  logic [SEL_W-1:0]     cmp_sel,
    input  logic                 cmp_signal,
    input  logic                 cmp_any_nan,
    input  logic                 cmp_any_snan,
    input  logic                 wr_valid,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    status,
    output logic                 trap_req,
    output logic [RND_MODES-1:0] rnd_onehot
);

    localparam logic [WORD_W-1:0] WMASK = store_mask();

    logic [WORD_W-1:0]  status_q, status_d;
    st_e                state_q, state_d;
    logic [CC_SETS-1:0] cc_we;
    logic [CC_W-1:0]    cc_val;
    logic               cmp_invalid;
    logic [EXC_W-1:0]   flags_eff;
    logic               any_flag, trap_hit, take_trap;
    logic [EXC_W-1:0]   cexc_d, aexc_d;

    fpsr_cc_unit u_cc (
        .cmp_valid    (cmp_valid),
        .cmp_rel      (cmp_rel),
        .cmp_sel      (cmp_sel),
        .cmp_signal   (cmp_signal),
        .cmp_any_nan  (cmp_any_nan),
        .cmp_any_snan (cmp_any_snan),
        .cc_we        (cc_we),
        .cc_val       (cc_val),
        .cmp_invalid  (cmp_invalid)
    );

    // compare outranks an operation in the same cycle
    always_comb begin
        flags_eff = '0;
        if (cmp_valid)
            flags_eff[EXC_NV] = cmp_invalid;
        else if (op_valid)
            flags_eff = op_flags;
    end

    fpsr_exc_unit u_exc (
        .flags_in (flags_eff),
        .cexc_q   (status_q[CEXC_LSB +: EXC_W]),
        .aexc_q   (status_q[AEXC_LSB +: EXC_W]),
        .tem_q    (status_q[TEM_LSB +: EXC_W]),
        .any_flag (any_flag),
        .trap_hit (trap_hit),
        .cexc_d   (cexc_d),
        .aexc_d   (aexc_d)
    );

    fpsr_rnd_decode u_rnd (
        .rnd_field  (status_q[RND_LSB +: RND_W]),
        .rnd_onehot (rnd_onehot)
    );

    // next status word: store > compare > operation
    always_comb begin
        status_d  = status_q;
        take_trap = 1'b0;
        if (wr_valid) begin
            status_d = (status_q & ~WMASK) | (wr_data & WMASK);
            status_d[TT_LSB +: TT_W] = '0;
        end else begin
            for (int i = 0; i < CC_SETS; i++) begin
                if (cc_we[i]) status_d[cc_lsb(i) +: CC_W] = cc_val;
            end
            if (any_flag) begin
                status_d[CEXC_LSB +: EXC_W] = cexc_d;
                status_d[AEXC_LSB +: EXC_W] = aexc_d;
                if (trap_hit) begin
                    status_d[TT_LSB +: TT_W] = TT_IEEE;
                    take_trap = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = take_trap ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_d = take_trap ? ST_TRAP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // controller: outputs
    always_comb begin
        trap_req = 1'b0;
        unique case (state_q)
            ST_IDLE: trap_req = 1'b0;
            ST_TRAP: trap_req = 1'b1;
            default: trap_req = 1'b0;
        endcase
    end

    assign status = status_q;

endmodule

// File: rtl/fpsr_ctl_chk.sv
module fpsr_ctl_chk
    import fpsr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic [EXC_W-1:0]     op_flags,
    input logic                 cmp_valid,
    input logic                 wr_valid,
    input logic [WORD_W-1:0]    status,
    input logic                 trap_req,
    input logic [RND_MODES-1:0] rnd_onehot
);

    assert_rnd_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rnd_onehot) == 1);

    assert_zero_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_flags == '0 && !cmp_valid && !wr_valid) |=> $stable(status));

    assert_trap_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (status[TT_LSB +: TT_W] == TT_IEEE
                      && (status[CEXC_LSB +: EXC_W] & status[TEM_LSB +: EXC_W]) != '0));

    assert_tt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[TT_LSB +: TT_W] == TT_IEEE && !wr_valid) |=> status[TT_LSB +: TT_W] == TT_IEEE);

    assert_store_clears_tt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (status[TT_LSB +: TT_W] == '0 && !trap_req));

    assert_accrued_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> ((status[AEXC_LSB +: EXC_W] & $past(status[AEXC_LSB +: EXC_W]))
                        == $past(status[AEXC_LSB +: EXC_W])));

endmodule

bind fpsr_ctl fpsr_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_flags   (op_flags),
    .cmp_valid  (cmp_valid),
    .wr_valid   (wr_valid),
    .status     (status),
    .trap_req   (trap_req),
    .rnd_onehot (rnd_onehot)
);

// File: tb/tb_fpsr_ctl.sv
module tb_fpsr_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [1:0]  cmp_sel = '0;
    logic        cmp_signal = 1'b0;
    logic        cmp_any_nan = 1'b0;
    logic        cmp_any_snan = 1'b0;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] status;
    logic        trap_req;
    logic [3:0]  rnd_onehot;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [63:0] m_word = '0;
    bit          m_trap = 1'b0;
    localparam logic [63:0] STORE_BITS = 64'h0000_003F_CF80_0FFF;
    int cc_shift [4] = '{0, 22, 24, 26};

    fpsr_ctl dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
        .cmp_valid(cmp_valid), .cmp_rel(cmp_rel), .cmp_sel(cmp_sel),
        .cmp_signal(cmp_signal), .cmp_any_nan(cmp_any_nan), .cmp_any_snan(cmp_any_snan),
        .wr_valid(wr_valid), .wr_data(wr_data), .status(status),
        .trap_req(trap_req), .rnd_onehot(rnd_onehot)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int flags;
        int cx;
        m_trap = 1'b0;
        if (wr_valid) begin
            m_word = (m_word & ~STORE_BITS) | (wr_data & STORE_BITS);
            m_word[16:14] = 3'd0;
        end else begin
            flags = 0;
            if (cmp_valid) begin
                m_word[10 + cc_shift[cmp_sel] +: 2] = cmp_rel;
                if ((cmp_signal && cmp_any_nan) || cmp_any_snan) flags = 16;
            end else if (op_valid) begin
                flags = op_flags;
            end
            if (flags != 0) begin
                cx = m_word[4:0] | flags;
                m_word[4:0] = cx[4:0];
                if ((cx & m_word[27:23]) != 0) begin
                    m_word[16:14] = 3'd1;
                    m_trap = 1'b1;
                end else begin
                    m_word[9:5] = m_word[9:5] | cx[4:0];
                end
            end
        end
    endtask

    // one clock: inputs already driven; compare every output afterwards
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(cur_req, status, m_word);
        check(cur_req, {63'd0, trap_req}, {63'd0, m_trap});
        check(cur_req, {60'd0, rnd_onehot}, 64'd1 << m_word[31:30]);
        op_valid = 0; op_flags = 0; cmp_valid = 0; wr_valid = 0; wr_data = 0;
        cmp_signal = 0; cmp_any_nan = 0; cmp_any_snan = 0; cmp_rel = 0; cmp_sel = 0;
    endtask

    task automatic do_store(input logic [63:0] d);
        wr_valid = 1; wr_data = d; tick();
    endtask

    task automatic do_op(input logic [4:0] f);
        op_valid = 1; op_flags = f; tick();
    endtask

    task automatic do_cmp(input logic [1:0] rel, input logic [1:0] sel, input logic sig,
                          input logic nan, input logic snan);
        cmp_valid = 1; cmp_rel = rel; cmp_sel = sel; cmp_signal = sig;
        cmp_any_nan = nan; cmp_any_snan = snan; tick();
    endtask

    initial begin : watchdog
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [63:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1", status, 64'd0);
        check("R1", {63'd0, trap_req}, 64'd0);
        check("R1", {60'd0, rnd_onehot}, 64'd1);

        // R8: every rounding code
        cur_req = "R8";
        for (int r = 0; r < 4; r++) begin
            do_store(64'(r) << 30);
            check("R8", {60'd0, rnd_onehot}, 64'd1 << r);
        end
        do_store(64'd0);

        // R2 / R3: untrapped flags accumulate and accrue
        cur_req = "R2";
        do_op(5'b00001);
        check("R2", {59'd0, status[4:0]}, 64'h01);
        do_op(5'b01000);
        check("R2", {59'd0, status[4:0]}, 64'h09);
        cur_req = "R3";
        check("R3", {59'd0, status[9:5]}, 64'h09);

        // R5: all-zero flags
        cur_req = "R5";
        snap = status;
        do_op(5'b00000);
        check("R5", status, snap);

        // R9: store masking
        cur_req = "R9";
        do_store('1);
        check("R9", status, STORE_BITS);
        do_store(64'd0);
        check("R9", status, 64'd0);

        // R4 / R11: enabled overflow traps
        cur_req = "R4";
        do_store(64'd1 << 26);
        do_op(5'b01000);
        check("R4", {63'd0, trap_req}, 64'd1);
        check("R4", {61'd0, status[16:14]}, 64'd1);
        check("R4", {59'd0, status[9:5]}, 64'd0);
        cur_req = "R11";
        tick();
        check("R4", {63'd0, trap_req}, 64'd0);
        check("R11", {61'd0, status[16:14]}, 64'd1);
        do_op(5'b00001);
        check("R4", {63'd0, trap_req}, 64'd1);
        do_store(64'd0);
        check("R11", {61'd0, status[16:14]}, 64'd0);

        // R6: every relation into every set
        cur_req = "R6";
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 4; r++) begin
                do_cmp(2'(r), 2'(s), 1'b0, r == 3, 1'b0);
                check("R6", {62'd0, status[10 + cc_shift[s] +: 2]}, 64'(r));
            end
        end
        do_store(64'd0);

        // R7: quiet vs signalling compare
        cur_req = "R7";
        do_cmp(2'b11, 2'd0, 1'b0, 1'b1, 1'b0);
        check("R7", {63'd0, status[4]}, 64'd0);
        do_cmp(2'b11, 2'd1, 1'b1, 1'b1, 1'b0);
        check("R7", {63'd0, status[4]}, 64'd1);
        do_store(64'd0);
        do_cmp(2'b11, 2'd2, 1'b0, 1'b1, 1'b1);
        check("R7", {63'd0, status[4]}, 64'd1);
        do_store(64'd1 << 27);
        do_cmp(2'b11, 2'd3, 1'b1, 1'b1, 1'b0);
        check("R7", {63'd0, trap_req}, 64'd1);
        do_store(64'd0);

        // R10: priority
        cur_req = "R10";
        wr_valid = 1; wr_data = 64'h0000_0000_4000_0000;
        op_valid = 1; op_flags = 5'b11111;
        cmp_valid = 1; cmp_rel = 2'b10; cmp_sel = 2'd0;
        tick();
        check("R10", status, 64'h0000_0000_4000_0000);
        cmp_valid = 1; cmp_rel = 2'b01; cmp_sel = 2'd1;
        op_valid = 1; op_flags = 5'b00010;
        tick();
        check("R10", {59'd0, status[4:0]}, 64'd0);
        check("R10", {62'd0, status[33:32]}, 64'd1);

        // mixed traffic against the reference model
        cur_req = "R2";
        for (int k = 0; k < 400; k++) begin
            int pick;
            pick = $urandom_range(0, 9);
            if (pick == 0) begin
                wr_valid = 1;
                wr_data = {$urandom(), $urandom()} & ~(64'h1F << 23) | (64'($urandom_range(0, 31) & 5'h3) << 23);
            end
            if (pick >= 1 && pick <= 5) begin
                op_valid = 1; op_flags = 5'($urandom_range(0, 31));
            end
            if (pick >= 4 && pick <= 7) begin
                cmp_valid = 1; cmp_rel = 2'($urandom_range(0, 3)); cmp_sel = 2'($urandom_range(0, 3));
                cmp_signal = 1'($urandom_range(0, 1));
                cmp_any_nan = (cmp_rel == 2'b11);
                cmp_any_snan = cmp_any_nan && ($urandom_range(0, 3) == 0);
            end
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule